// File: doc/BRIEF.md
# System Call Entry Stage

This stage computes the architectural state change made when a system-call instruction is taken. It receives the current machine state register (MSR), the address of the system-call instruction and that instruction's 7-bit privilege-level field, qualified by an input valid. One clock later it presents the MSR to install, the return address and status word to save for the handler, the address to fetch next, and a write strobe for each saved or updated register.

The new MSR forces the processor into a safe handler context. It sets 64-bit mode and little-endian mode, and it clears translation, interrupt enables, problem state, the facility enables and the trace and transactional controls. The hypervisor bit is taken from the level field. A suspended transaction state is folded into the transactional state. The saved status word keeps most of the old MSR but zeroes two reserved ranges. The next fetch address is a fixed vector set by a parameter.

Bit numbers below count from the least significant bit (bit 0) of a 64-bit word.

Top module: `syscall_entry`

## Requirements
- R1: `out_valid`, `msr_we`, `save_pc_we` and `save_status_we` each equal `in_valid` from the previous clock, and all of them are 0 during and right after reset.
- R2: `save_pc` is `cur_pc + 4` modulo 2^64, taken from the accepted input.
- R3: `save_status` bits 30 to 27 and bits 21 to 16 are 0.
- R4: All other `save_status` bits (63 to 31, 26 to 22, 15 to 0) equal the same bits of the accepted `cur_msr`.
- R5: `new_msr` has bits 63 (64-bit mode) and 0 (little-endian) set, and bits 58, 32, 25, 23, 15, 14, 13, 11, 10, 9, 8, 5, 4, 3 and 1 cleared.
- R6: `new_msr` bit 60 (hypervisor) is 1 when `sc_level` equals 1 and 0 for every other level value.
- R7: The transaction-state pair {bit 34, bit 33} of `new_msr` is 2'b01 when the input pair is 2'b10. Otherwise it equals the input pair.
- R8: Every `new_msr` bit not named in R5, R6 or R7 equals the same bit of the accepted `cur_msr`.
- R9: `new_pc` equals the `VECTOR` parameter (default 64'h0C00) whenever `out_valid` is 1.
- R10: When `in_valid` is 0, `new_msr`, `save_pc`, `save_status` and `new_pc` keep their values from the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A system call is presented this cycle |
| cur_msr | input | 64 | MSR before the call |
| cur_pc | input | PC_W | Address of the system-call instruction |
| sc_level | input | 7 | Privilege-level field of the instruction |
| out_valid | output | 1 | Results below are for an accepted call |
| new_msr | output | 64 | MSR for the handler |
| msr_we | output | 1 | Write strobe for `new_msr` |
| save_pc | output | PC_W | Return address to save |
| save_pc_we | output | 1 | Write strobe for `save_pc` |
| save_status | output | 64 | Status word to save |
| save_status_we | output | 1 | Write strobe for `save_status` |
| new_pc | output | PC_W | Next fetch address |

## Verification
Every result is due exactly one rising edge after the input is accepted, because each output passes through one register. The bench drives inputs on the falling edge and queues the bit-level expectation. The monitor samples one time unit after the following rising edge and pops one entry for every cycle in which `out_valid` is high. When `out_valid` is low, an empty queue is expected and the data outputs are compared with the last popped entry, which checks that they hold.

// File: rtl/syscall_pkg.sv
package syscall_pkg;

  localparam int MSR_W = 64;
  localparam int LVL_W = 7;

  // MSR bit positions, LSB = 0
  localparam int B_MODE64 = 63;
  localparam int B_HYPER  = 60;
  localparam int B_UNDEF  = 58;
  localparam int B_TSHI   = 34;
  localparam int B_TSLO   = 33;
  localparam int B_TXEN   = 32;
  localparam int B_VECU   = 25;
  localparam int B_VSXU   = 23;
  localparam int B_EXTIE  = 15;
  localparam int B_PROB   = 14;
  localparam int B_FPU    = 13;
  localparam int B_FEXA   = 11;
  localparam int B_TRHI   = 10;
  localparam int B_TRLO   = 9;
  localparam int B_FEXB   = 8;
  localparam int B_ITRAN  = 5;
  localparam int B_DTRAN  = 4;
  localparam int B_PMARK  = 3;
  localparam int B_RECOV  = 1;
  localparam int B_LEND   = 0;

  localparam logic [MSR_W-1:0] ONE = {{(MSR_W-1){1'b0}}, 1'b1};

  localparam logic [MSR_W-1:0] MSR_CLR =
      (ONE << B_UNDEF) | (ONE << B_TXEN)  | (ONE << B_VECU)  | (ONE << B_VSXU) |
      (ONE << B_EXTIE) | (ONE << B_PROB)  | (ONE << B_FPU)   | (ONE << B_FEXA) |
      (ONE << B_TRHI)  | (ONE << B_TRLO)  | (ONE << B_FEXB)  | (ONE << B_ITRAN) |
      (ONE << B_DTRAN) | (ONE << B_PMARK) | (ONE << B_RECOV);

  localparam logic [MSR_W-1:0] MSR_SET = (ONE << B_MODE64) | (ONE << B_LEND);

  // Reserved ranges zeroed in the saved status word: bits 30..27 and 21..16
  localparam logic [MSR_W-1:0] STAT_ZERO = (64'hF << 27) | (64'h3F << 16);

  function automatic logic is_hyper_level(input logic [LVL_W-1:0] lvl);
    return lvl == LVL_W'(1);
  endfunction

  function automatic logic [1:0] fold_ts(input logic [1:0] ts);
    return (ts == 2'b10) ? 2'b01 : ts;
  endfunction

  function automatic logic [MSR_W-1:0] handler_msr(input logic [MSR_W-1:0] msr,
                                                   input logic [LVL_W-1:0] lvl);
    logic [MSR_W-1:0] m;
    logic [1:0]       ts;
    m  = (msr & ~MSR_CLR) | MSR_SET;
    ts = fold_ts({msr[B_TSHI], msr[B_TSLO]});
    m[B_TSHI]  = ts[1];
    m[B_TSLO]  = ts[0];
    m[B_HYPER] = is_hyper_level(lvl);
    return m;
  endfunction

  function automatic logic [MSR_W-1:0] saved_status(input logic [MSR_W-1:0] msr);
    return msr & ~STAT_ZERO;
  endfunction

endpackage

// File: rtl/syscall_msr_calc.sv
module syscall_msr_calc
  import syscall_pkg::*;
(
  input  logic [MSR_W-1:0] msr_in,
  input  logic [LVL_W-1:0] level,
  output logic [MSR_W-1:0] msr_out,
  output logic             hv_hit,
  output logic             ts_fold
);
  always_comb begin
    msr_out = handler_msr(msr_in, level);
    hv_hit  = is_hyper_level(level);
    ts_fold = msr_in[B_TSHI] & ~msr_in[B_TSLO];
  end
endmodule

// File: rtl/syscall_status_calc.sv
module syscall_status_calc
  import syscall_pkg::*;
(
  input  logic [MSR_W-1:0] msr_in,
  output logic [MSR_W-1:0] status_out
);
  always_comb status_out = saved_status(msr_in);
endmodule

// File: rtl/syscall_ret_calc.sv
module syscall_ret_calc #(
  parameter int PC_W   = 64,
  parameter int INSN_B = 4
) (
  input  logic [PC_W-1:0] pc_in,
  output logic [PC_W-1:0] ret_out
);
  localparam logic [PC_W-1:0] STEP = PC_W'(INSN_B);
  always_comb ret_out = pc_in + STEP;
endmodule

// File: rtl/syscall_entry.sv
module syscall_entry
  import syscall_pkg::*;
#(
  parameter int              PC_W   = 64,
  parameter logic [PC_W-1:0] VECTOR = PC_W'(64'h0C00)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [MSR_W-1:0] cur_msr,
  input  logic [PC_W-1:0]  cur_pc,
  input  logic [LVL_W-1:0] sc_level,
  output logic             out_valid,
  output logic [MSR_W-1:0] new_msr,
  output logic             msr_we,
  output logic [PC_W-1:0]  save_pc,
  output logic             save_pc_we,
  output logic [MSR_W-1:0] save_status,
  output logic             save_status_we,
  output logic [PC_W-1:0]  new_pc
);
  logic [MSR_W-1:0] msr_nx;
  logic [MSR_W-1:0] stat_nx;
  logic [PC_W-1:0]  ret_nx;
  logic             hv_hit;
  logic             ts_fold;

  syscall_msr_calc u_msr (
    .msr_in (cur_msr),
    .level  (sc_level),
    .msr_out(msr_nx),
    .hv_hit (hv_hit),
    .ts_fold(ts_fold)
  );

  syscall_status_calc u_stat (
    .msr_in    (cur_msr),
    .status_out(stat_nx)
  );

  syscall_ret_calc #(.PC_W(PC_W)) u_ret (
    .pc_in  (cur_pc),
    .ret_out(ret_nx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid      <= 1'b0;
      msr_we         <= 1'b0;
      save_pc_we     <= 1'b0;
      save_status_we <= 1'b0;
    end else begin
      out_valid      <= in_valid;
      msr_we         <= in_valid;
      save_pc_we     <= in_valid;
      save_status_we <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_msr     <= '0;
      save_pc     <= '0;
      save_status <= '0;
      new_pc      <= '0;
    end else if (in_valid) begin
      new_msr     <= msr_nx;
      save_pc     <= ret_nx;
      save_status <= stat_nx;
      new_pc      <= VECTOR;
    end
  end
endmodule

// File: rtl/syscall_entry_chk.sv
module syscall_entry_chk
  import syscall_pkg::*;
#(
  parameter int              PC_W   = 64,
  parameter logic [PC_W-1:0] VECTOR = PC_W'(64'h0C00)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [MSR_W-1:0] cur_msr,
  input logic [PC_W-1:0]  cur_pc,
  input logic             out_valid,
  input logic             msr_we,
  input logic             save_pc_we,
  input logic             save_status_we,
  input logic [MSR_W-1:0] new_msr,
  input logic [PC_W-1:0]  save_pc,
  input logic [MSR_W-1:0] save_status,
  input logic [PC_W-1:0]  new_pc,
  input logic             hv_hit,
  input logic             ts_fold
);
  AST_VALID_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid)); // R1
  AST_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (msr_we == out_valid) && (save_pc_we == out_valid) && (save_status_we == out_valid)); // R1
  AST_RET_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> save_pc == $past(cur_pc) + PC_W'(4)); // R2
  AST_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (save_status[30:27] == 4'h0) && (save_status[21:16] == 6'h0)); // R3
  AST_STATUS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (save_status[63:31] == $past(cur_msr[63:31])) &&
                 (save_status[26:22] == $past(cur_msr[26:22])) &&
                 (save_status[15:0]  == $past(cur_msr[15:0]))); // R4
  AST_MODE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> new_msr[B_MODE64] && new_msr[B_LEND] && !new_msr[B_EXTIE] &&
                  !new_msr[B_PROB] && !new_msr[B_ITRAN] && !new_msr[B_DTRAN]); // R5
  AST_HYPER: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> new_msr[B_HYPER] == $past(hv_hit)); // R6
  AST_TS_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && ts_fold) |=> ({new_msr[B_TSHI], new_msr[B_TSLO]} == 2'b01)); // R7
  AST_PASS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (new_msr[62:61] == $past(cur_msr[62:61])) &&
                 (new_msr[12] == $past(cur_msr[12]))); // R8
  AST_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> new_pc == VECTOR); // R9
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(new_msr) && $stable(save_pc) && $stable(save_status)); // R10
endmodule

bind syscall_entry syscall_entry_chk #(.PC_W(PC_W), .VECTOR(VECTOR)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cur_msr(cur_msr), .cur_pc(cur_pc),
  .out_valid(out_valid), .msr_we(msr_we), .save_pc_we(save_pc_we),
  .save_status_we(save_status_we), .new_msr(new_msr), .save_pc(save_pc),
  .save_status(save_status), .new_pc(new_pc), .hv_hit(hv_hit), .ts_fold(ts_fold)
);

// File: tb/syscall_entry_test.sv
`timescale 1ns/1ps
module syscall_entry_test;
  localparam int PC_W = 64;
  localparam logic [63:0] VEC = 64'h0C00;

  typedef struct packed {
    logic [63:0] msr;
    logic [63:0] ret;
    logic [63:0] stat;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] cur_msr = '0;
  logic [63:0] cur_pc = '0;
  logic [6:0]  sc_level = '0;
  logic        out_valid, msr_we, save_pc_we, save_status_we;
  logic [63:0] new_msr, save_pc, save_status, new_pc;

  int checks = 0;
  int fails = 0;
  exp_t q[$];
  exp_t last;
  bit   have_last = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  syscall_entry uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cur_msr(cur_msr),
    .cur_pc(cur_pc), .sc_level(sc_level), .out_valid(out_valid),
    .new_msr(new_msr), .msr_we(msr_we), .save_pc(save_pc),
    .save_pc_we(save_pc_we), .save_status(save_status),
    .save_status_we(save_status_we), .new_pc(new_pc)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  // Model written with architectural (MSB = 0) bit numbers
  function automatic logic bit_be(input logic [63:0] v, input int be);
    return v[63-be];
  endfunction

  function automatic exp_t model(input logic [63:0] m, input logic [63:0] pc, input logic [6:0] lv);
    exp_t e;
    int clr[16] = '{5, 31, 38, 40, 48, 49, 50, 52, 53, 54, 55, 58, 59, 60, 62, 62};
    e.msr = m;
    foreach (clr[i]) e.msr[63-clr[i]] = 1'b0;
    e.msr[63-0]  = 1'b1;
    e.msr[63-63] = 1'b1;
    e.msr[63-3]  = (lv == 7'd1);
    if (bit_be(m, 29) && !bit_be(m, 30)) begin
      e.msr[63-29] = 1'b0;
      e.msr[63-30] = 1'b1;
    end
    for (int be = 0; be < 64; be++)
      e.stat[63-be] = ((be >= 33 && be <= 36) || (be >= 42 && be <= 47)) ? 1'b0 : bit_be(m, be);
    e.ret = pc + 64'd4;
    return e;
  endfunction

  task automatic send(input logic [63:0] m, input logic [63:0] pc, input logic [6:0] lv);
    @(negedge clk);
    in_valid = 1'b1; cur_msr = m; cur_pc = pc; sc_level = lv;
    q.push_back(model(m, pc, lv));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      cur_msr = {$urandom, $urandom}; cur_pc = {$urandom, $urandom}; sc_level = 7'($urandom);
    end
  endtask

  // Monitor: results are due one rising edge after acceptance
  initial begin
    @(posedge rst_n);
    forever begin
      @(posedge clk);
      #1;
      if (done) break;
      chk("R1 msr_we", 64'(msr_we), 64'(out_valid));
      chk("R1 save_pc_we", 64'(save_pc_we), 64'(out_valid));
      chk("R1 save_status_we", 64'(save_status_we), 64'(out_valid));
      if (out_valid) begin
        if (q.size() == 0) chk("R1 spurious valid", 64'd1, 64'd0);
        else begin
          last = q.pop_front();
          have_last = 1;
          chk("R2 save_pc", save_pc, last.ret);
          chk("R3 status zero ranges", save_status & ((64'hF << 27) | (64'h3F << 16)), 64'd0);
          chk("R4 save_status", save_status, last.stat);
          chk("R5 mode bits", {62'd0, new_msr[63], new_msr[0]}, 64'd3);
          chk("R6 hyper bit", 64'(new_msr[60]), 64'(last.msr[60]));
          chk("R7 ts pair", 64'({new_msr[34], new_msr[33]}), 64'({last.msr[34], last.msr[33]}));
          chk("R8 new_msr", new_msr, last.msr);
          chk("R9 new_pc", new_pc, VEC);
        end
      end else begin
        chk("R1 missing valid", 64'(q.size()), 64'd0);
        if (have_last) begin
          chk("R10 hold msr", new_msr, last.msr);
          chk("R10 hold ret", save_pc, last.ret);
          chk("R10 hold status", save_status, last.stat);
          chk("R10 hold pc", new_pc, VEC);
        end
      end
    end
  end

  initial begin : watchdog
    #200000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", 64'(out_valid), 64'd0);
    chk("R1 reset strobes", 64'({msr_we, save_pc_we, save_status_we}), 64'd0);
    rst_n = 1'b1;
    idle(2);
    send(64'hFFFF_FFFF_FFFF_FFFF, 64'h1000, 7'd1);          // R6 level 1, R7 ts=11
    send(64'h0, 64'h2000, 7'd0);                            // R5 set bits from zero
    idle(3);                                                // R10
    send(64'h0000_0004_0000_0000, 64'h3004, 7'd2);          // R7 ts=10 -> 01
    send(64'h0000_0002_0000_0000, 64'h3008, 7'd127);        // R7 ts=01 unchanged
    send(64'hA5A5_5A5A_F0F0_0F0F, 64'hFFFF_FFFF_FFFF_FFFE, 7'd1); // R2 wrap
    idle(1);
    for (int i = 0; i < 40; i++) begin
      send({$urandom, $urandom}, {$urandom, $urandom}, (i % 3 == 0) ? 7'd1 : 7'($urandom));
      if (i % 5 == 0) idle(1 + (i % 3));
    end
    idle(4);
    done = 1;
    @(posedge clk); #2;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule